// File: doc/BRIEF.md
# Zero-High-Bits Execution Unit

This integer execution unit takes a source operand and an index operand and returns the source with every bit at or above the index cleared, leaving the bits under the index untouched. The index is the low byte of the second operand. It does not wrap. When the index reaches or passes the operand width, the source comes through unchanged within that width and the carry flag is raised. The unit also produces zero, sign and overflow results, and it drives the two undefined flags to a fixed value.

Operations arrive on a valid/ready issue port. Each one carries both operands, a wide-size request bit, a long-mode indicator and the decoded vector-length bit. The result appears one registered stage later on a valid/ready result port, together with the flags and an illegal-encoding indication. A non-zero vector-length bit turns the operation into an illegal-encoding result with no data and no flags. The 64-bit width is selected only when long mode and the wide request are both set. In every other case the operation works on 32 bits, and the upper half of the result is zero.

Top module: `zhb_exec`

## Requirements
- R1: The index N is in_src2[7:0]. Bits 63:8 of in_src2 have no effect on any output.
- R2: When N is below the active width, out_dest bits from N up to the top of the width are 0. Bits below N equal in_src1.
- R3: When N is at or above the active width, out_dest equals in_src1 within the active width.
- R4: out_cf is 1 exactly when N is greater than the active width minus one, and 0 otherwise.
- R5: out_zf is 1 exactly when out_dest is zero. out_sf equals the top bit of the active width of out_dest (bit 63 for 64-bit, bit 31 for 32-bit).
- R6: out_of, out_af and out_pf are always 0.
- R7: The active width is 64 only when in_long_mode=1 and in_wide=1. Otherwise it is 32, and in_wide is ignored outside long mode.
- R8: When in_vlen=1, the result has out_undef=1, out_dest=0 and all flags 0. Otherwise out_undef=0.
- R9: For a 32-bit operation, out_dest[63:32] is 0.
- R10: An operation accepted on a rising edge (in_valid && in_ready) is presented with out_valid=1 after that edge. in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, all result outputs stay stable.
- R11: A synchronous active-low reset (rst_n=0 at a rising edge) clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue request valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_src1 | input | 64 | Data operand |
| in_src2 | input | 64 | Index operand (low byte used) |
| in_wide | input | 1 | Requests a 64-bit operation |
| in_long_mode | input | 1 | Unit runs in 64-bit mode |
| in_vlen | input | 1 | Decoded vector-length bit |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | 64 | Result data |
| out_cf | output | 1 | Carry: index past width |
| out_zf | output | 1 | Zero result |
| out_sf | output | 1 | Sign of result |
| out_of | output | 1 | Overflow, always 0 |
| out_af | output | 1 | Undefined flag, driven 0 |
| out_pf | output | 1 | Undefined flag, driven 0 |
| out_undef | output | 1 | Illegal encoding indication |

## Verification
Directed cases put the index at 0, at width minus one, at exactly the width, and at 255, in both widths. These separate an off-by-one in the clear boundary or in the carry comparison from a correct one. Random vectors fill the upper bytes of the index operand with noise, which exposes any use of bits above the low byte or any modulo wrap. They also mix all four combinations of long mode and wide request, so a width decode that honours the wide bit outside long mode stands out. A stalled result port with a second operation waiting shows whether the result holds and whether the queued operation is lost or duplicated.

// File: rtl/zhb_pkg.sv
// zhb_pkg: shared types for the zero-high-bits unit.
// Assumes: flag set is fixed; data width is parameterised at the modules.
package zhb_pkg;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic af;
        logic pf;
    } zhb_flags_t;

    localparam int ZHB_IDX_W = 8;

endpackage

// File: rtl/zhb_size_sel.sv
// zhb_size_sel: picks the active operand width and flags illegal encodings.
// Assumes: the wide request counts only in long mode.
module zhb_size_sel (
    input  logic in_wide,
    input  logic in_long_mode,
    input  logic in_vlen,
    output logic use_wide,
    output logic illegal
);
    // Width decision and vector-length legality check.
    always_comb begin
        use_wide = in_long_mode & in_wide;
        illegal  = in_vlen;
    end
endmodule

// File: rtl/zhb_mask_unit.sv
// zhb_mask_unit: keeps source bits below the index, clears the rest.
// Assumes: idx is unsigned and never wraps; bits above the active width
// are forced to zero for the narrow size.
module zhb_mask_unit #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IDX_W    = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [IDX_W-1:0]  idx,
    input  logic              use_wide,
    output logic [DATA_W-1:0] dest,
    output logic              idx_over
);
    localparam logic [IDX_W-1:0] WIDE_LIM   = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] NARROW_LIM = IDX_W'(NARROW_W);

    logic [DATA_W-1:0] keep;

    // Per-bit keep decision: below index and inside the active width.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_low
            assign keep[i] = (idx > IDX_W'(i));
        end else begin : g_high
            assign keep[i] = use_wide & (idx > IDX_W'(i));
        end
    end

    // Apply the keep mask to the source.
    assign dest = src & keep;

    // Index past the last bit of the active width.
    always_comb begin
        if (use_wide) idx_over = (idx >= WIDE_LIM);
        else          idx_over = (idx >= NARROW_LIM);
    end
endmodule

// File: rtl/zhb_flag_unit.sv
// zhb_flag_unit: derives condition flags from the masked result.
// Assumes: dest already zero above the active width; illegal encodings
// clear every flag.
module zhb_flag_unit #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0]    dest,
    input  logic                 use_wide,
    input  logic                 idx_over,
    input  logic                 illegal,
    output zhb_pkg::zhb_flags_t  flags
);
    // Flag computation, suppressed for illegal encodings.
    always_comb begin
        flags = '0;
        if (!illegal) begin
            flags.cf = idx_over;
            flags.zf = (dest == '0);
            flags.sf = use_wide ? dest[DATA_W-1] : dest[NARROW_W-1];
        end
    end
endmodule

// File: rtl/zhb_exec.sv
// zhb_exec: zero-high-bits execution unit with one registered stage.
// Assumes: upstream holds inputs while in_valid && !in_ready; reset is
// synchronous active-low.
module zhb_exec #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_src1,
    input  logic [DATA_W-1:0] in_src2,
    input  logic              in_wide,
    input  logic              in_long_mode,
    input  logic              in_vlen,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_dest,
    output logic              out_cf,
    output logic              out_zf,
    output logic              out_sf,
    output logic              out_of,
    output logic              out_af,
    output logic              out_pf,
    output logic              out_undef
);
    import zhb_pkg::*;
    localparam int IDX_W = ZHB_IDX_W;

    logic              use_wide;
    logic              illegal;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] dest_c;
    logic              idx_over;
    zhb_flags_t        flags_c;

    logic              valid_q;
    logic [DATA_W-1:0] dest_q;
    zhb_flags_t        flags_q;
    logic              undef_q;

    zhb_size_sel u_size (
        .in_wide      (in_wide),
        .in_long_mode (in_long_mode),
        .in_vlen      (in_vlen),
        .use_wide     (use_wide),
        .illegal      (illegal)
    );

    zhb_mask_unit #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .IDX_W    (IDX_W)
    ) u_mask (
        .src      (in_src1),
        .idx      (in_src2[IDX_W-1:0]),
        .use_wide (use_wide),
        .dest     (masked),
        .idx_over (idx_over)
    );

    // Illegal encodings carry no data.
    assign dest_c = illegal ? '0 : masked;

    zhb_flag_unit #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_flag (
        .dest     (dest_c),
        .use_wide (use_wide),
        .idx_over (idx_over),
        .illegal  (illegal),
        .flags    (flags_c)
    );

    // Stage accepts when empty or when its result is being taken.
    assign in_ready = !valid_q || out_ready;

    // Valid bit of the result stage.
    always_ff @(posedge clk) begin
        if (!rst_n)        valid_q <= 1'b0;
        else if (in_ready) valid_q <= in_valid;
    end

    // Result payload captured on accepted operations only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q  <= '0;
            flags_q <= '0;
            undef_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            dest_q  <= dest_c;
            flags_q <= flags_c;
            undef_q <= illegal;
        end
    end

    // Drive result port from the stage registers.
    always_comb begin
        out_valid = valid_q;
        out_dest  = dest_q;
        out_cf    = flags_q.cf;
        out_zf    = flags_q.zf;
        out_sf    = flags_q.sf;
        out_of    = flags_q.of;
        out_af    = flags_q.af;
        out_pf    = flags_q.pf;
        out_undef = undef_q;
    end
endmodule

// File: rtl/zhb_exec_chk.sv
// zhb_exec_chk: protocol and result properties for zhb_exec, bound below.
// Assumes: it observes top-level ports only.
module zhb_exec_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_src1,
    input logic [DATA_W-1:0] in_src2,
    input logic              in_wide,
    input logic              in_long_mode,
    input logic              in_vlen,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_dest,
    input logic              out_cf,
    input logic              out_zf,
    input logic              out_sf,
    input logic              out_of,
    input logic              out_af,
    input logic              out_pf,
    input logic              out_undef
);
    assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_cf)
                                       && $stable(out_zf) && $stable(out_undef)));

    assert_fixed_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_of && !out_af && !out_pf));

    assert_illegal_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_vlen) |=> (out_undef && out_dest == '0 && !out_cf && !out_zf));

    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(in_long_mode && in_wide)) |=> (out_dest[DATA_W-1:NARROW_W] == '0));

    assert_zero_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_vlen && in_src2[7:0] == 8'd0) |=> (out_dest == '0 && out_zf && !out_cf));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_undef) |-> (out_zf == (out_dest == '0)));
endmodule

bind zhb_exec zhb_exec_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_zhb_exec.sv
`timescale 1ns/1ps
module sim_zhb_exec;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [63:0] in_src1, in_src2;
    logic        in_wide, in_long_mode, in_vlen;
    logic        out_valid, out_ready;
    logic [63:0] out_dest;
    logic        out_cf, out_zf, out_sf, out_of, out_af, out_pf, out_undef;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    zhb_exec u0 (.*);

    typedef struct packed {
        logic [63:0] dest;
        logic cf, zf, sf, undef;
    } exp_t;

    // Behavioural model straight from the requirements.
    function automatic exp_t model(logic [63:0] s1, logic [63:0] s2, logic w, logic lm, logic vl);
        exp_t e;
        int   size;
        int   n;
        logic [63:0] wmask;
        e = '0;
        if (vl) begin
            e.undef = 1'b1;
            return e;
        end
        size  = (lm && w) ? 64 : 32;
        n     = int'(s2[7:0]);
        wmask = (size == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
        if (n >= size) e.dest = s1 & wmask;
        else           e.dest = s1 & ((64'h1 << n) - 64'h1);
        e.cf = (n > size - 1);
        e.zf = (e.dest == 64'h0);
        e.sf = (size == 64) ? e.dest[63] : e.dest[31];
        return e;
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one operation and compare the result one cycle later.
    task automatic run(logic [63:0] s1, logic [63:0] s2, logic w, logic lm, logic vl, string tag);
        exp_t e;
        e = model(s1, s2, w, lm, vl);
        @(negedge clk);
        in_src1 = s1; in_src2 = s2; in_wide = w; in_long_mode = lm; in_vlen = vl;
        in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_dest == e.dest && out_cf == e.cf && out_zf == e.zf &&
              out_sf == e.sf && out_undef == e.undef && !out_of && !out_af && !out_pf,
              tag, {out_valid, out_undef, out_sf, out_zf, out_cf, out_dest},
              {1'b1, e.undef, e.sf, e.zf, e.cf, e.dest});
    endtask

    // Watchdog: a hung run still reports.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_t e1, e2;
        logic [63:0] a, b;
        void'($urandom(32'd1357));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_src1 = '0; in_src2 = '0; in_wide = 0; in_long_mode = 0; in_vlen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready, "R11 reset", {126'h0, out_valid, in_ready}, 128'h1);
        rst_n = 1'b1;

        // Directed corners.
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'd0,   1, 1, 0, "R2 N=0 wide");
        run(64'hDEAD_BEEF_CAFE_F00D, 64'd0,   0, 0, 0, "R2 N=0 narrow");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'd31,  0, 1, 0, "R2 N=31 narrow");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'd32,  0, 1, 0, "R3 R4 N=32 narrow");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'd63,  1, 1, 0, "R2 R4 N=63 wide");
        run(64'h8123_4567_89AB_CDEF, 64'd64,  1, 1, 0, "R3 R4 N=64 wide");
        run(64'h8123_4567_89AB_CDEF, 64'd255, 1, 1, 0, "R3 R4 N=255 wide");
        run(64'h8123_4567_89AB_CDEF, 64'd255, 0, 0, 0, "R3 R9 N=255 narrow");
        run(64'h0000_0000_8000_0000, 64'd40,  1, 0, 0, "R7 R5 wide ignored");
        run(64'hFFFF_FFFF_FFFF_FF00, 64'h7FFF_FFFF_FFFF_FF05, 1, 1, 0, "R1 R5 upper src2 ignored");
        run(64'h1234, 64'hAB00_0000_0000_0120, 0, 0, 0, "R1 no wrap N=0x20");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'd10,  1, 1, 1, "R8 vlen wide");
        run(64'h0,                   64'd200, 0, 0, 1, "R8 vlen narrow");
        run(64'h0000_0000_0000_0000, 64'd100, 1, 1, 0, "R4 R5 zero src");

        // Back-pressure: first result must hold while a second waits.
        e1 = model(64'hAAAA_5555_AAAA_5555, 64'd17, 1, 1, 0);
        e2 = model(64'h1111_2222_3333_4444, 64'd48, 1, 1, 0);
        @(negedge clk);
        out_ready = 1'b0;
        in_src1 = 64'hAAAA_5555_AAAA_5555; in_src2 = 64'd17;
        in_wide = 1; in_long_mode = 1; in_vlen = 0; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_src1 = 64'h1111_2222_3333_4444; in_src2 = 64'd48;
        check(!in_ready, "R10 ready low on stall", {127'h0, in_ready}, 128'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_dest == e1.dest && out_cf == e1.cf, "R10 hold under stall",
              {63'h0, out_valid, out_dest}, {63'h0, 1'b1, e1.dest});
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_dest == e2.dest && out_cf == e2.cf, "R10 queued op delivered",
              {63'h0, out_valid, out_dest}, {63'h0, 1'b1, e2.dest});
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R10 no duplicate", {127'h0, out_valid}, 128'h0);

        // Constrained random mix.
        for (int k = 0; k < 600; k++) begin
            logic w, lm, vl;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) b[7:0] = 8'($urandom_range(0, 70));
            w  = 1'($urandom);
            lm = 1'($urandom);
            vl = ($urandom_range(0, 15) == 0);
            run(a, b, w, lm, vl, "R1 R2 R3 R4 R5 R7 R9 random");
        end

        // Reset mid-stream clears the result stage.
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R11 reset while holding", {127'h0, out_valid}, 128'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule